// File: doc/BRIEF.md
# Protected Memory Access Arbiter

This block rules on every access to a 34-word store of a contactless tag. Words 0 to 31 are rewritable, and words 32 and 33 are fixed identity words. Word 0 is the secret key, word 1 holds the protection ranges and word 2 holds the operating options. A command sequencer presents one request at a time as a kind and a word address. One cycle later the arbiter returns a verdict and tells the output serialiser whether the outgoing word must be replaced by zeros.

The arbiter keeps a snapshot of the protection and option words. It takes that snapshot only on a power-on pulse or a reset command, so values written to those words take effect only after the next reset. It also keeps a single session flag. A successful key check sets the flag, and either reset event clears it. From the option snapshot it derives the first and last addresses of the word loop that is sent continuously after a reset.

Top module: `prot_access_arbiter`

## Requirements
- R1: After the asynchronous reset `rst_n`, `rsp_valid` is 0, the session flag is clear and both snapshots are all zeros. As a result `first_rd` and `last_rd` read 0, and a write to word 5 is allowed.
- R2: A request accepted on a clock edge (`req_valid` = 1) produces `rsp_valid` = 1 with its verdict on the next edge. `rsp_valid` is 0 one cycle after a cycle with no request.
- R3: Request kinds are 0 = read, 1 = write, 2 = read-back after write and 3 = reserved. A write to word 0 is always refused. A read of word 0 is refused with `rsp_zero` = 1, even when a session is open.
- R4: A write to word 1 or 2 needs an open session, whatever the key-check option says. It is refused when that address lies inside the write-inhibit range.
- R5: For words 3 to 31, a write to an address inside the inhibit range is refused. An address outside that range is allowed when option bit 16 (key check) is 0, and allowed only with an open session when it is 1. The range limits are inclusive.
- R6: Writes to addresses 32 and above are refused. Reads of words 32 and 33 are allowed. Reads and read-backs of addresses above 33 are refused with `rsp_zero` = 1.
- R7: The protection word holds the first read-protected address in bits 7:0, the last read-protected address in bits 15:8, the first inhibited address in bits 23:16 and the last inhibited address in bits 31:24. A read inside the protected range (inclusive) is allowed with `rsp_zero` = 1 when no session is open, and with `rsp_zero` = 0 when one is.
- R8: A read-back is allowed only when option bit 17 is 1. When allowed, it ignores read protection and gives `rsp_zero` = 0. When refused, it gives `rsp_zero` = 1.
- R9: A `login_ok` pulse opens the session, and the session stays open across any number of requests. A `reset_cmd` or `pwr_on` pulse closes it, and a reset in the same cycle as `login_ok` wins.
- R10: The protection and option snapshots are reloaded from `prot_word` and `ctrl_word` only on a `reset_cmd` or `pwr_on` edge. Changes on those inputs at other times have no effect.
- R11: The option word holds the first loop address in bits 7:0 and the last in bits 15:8. When first ≤ last ≤ 33, `first_rd` and `last_rd` show them as stored. Otherwise both show the first address.
- R12: A reserved-kind request gets `rsp_allow` = 0 and `rsp_zero` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Power-on pulse: reload snapshots, close session |
| reset_cmd | input | 1 | Reset command pulse: reload snapshots, close session |
| login_ok | input | 1 | Key check succeeded |
| prot_word | input | 32 | Stored protection word |
| ctrl_word | input | 32 | Stored option word |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 read, 1 write, 2 read-back, 3 reserved |
| req_addr | input | 8 | Word address |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access granted |
| rsp_zero | output | 1 | Send the word as all zeros |
| first_rd | output | 8 | First address of the reset-time word loop |
| last_rd | output | 8 | Last address of the reset-time word loop |

## Verification
The assertions assume that the control inputs are single-cycle pulses sampled on rising edges. They also assume that `req_kind` and `req_addr` are stable whenever `req_valid` is high, so a verdict can be tied to the request of the previous edge. The bench drives every input on the falling edge and holds each request for exactly one cycle. It reloads the snapshots through `reset_cmd` before each table vector, so every verdict follows from a known option word, protection word and session state.

// File: rtl/prot_access_pkg.sv
package prot_access_pkg;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_RBACK = 2'd2,
      KIND_RSVD  = 2'd3
   } req_kind_e;

   typedef struct packed {
      logic allow;
      logic zero;
   } verdict_t;

endpackage

// File: rtl/pa_cfg_store.sv
module pa_cfg_store #(
   parameter int DATA_W = 32,
   parameter int N_CFG  = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pwr_on,
   input  logic                         reset_cmd,
   input  logic                         login_ok,
   input  logic [N_CFG-1:0][DATA_W-1:0] cfg_in,
   output logic [N_CFG-1:0][DATA_W-1:0] cfg_q,
   output logic                         session
);

   logic reload;
   assign reload = pwr_on | reset_cmd;

   for (genvar g = 0; g < N_CFG; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cfg_q[g] <= '0;
         else if (reload) cfg_q[g] <= cfg_in[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        session <= 1'b0;
      else if (reload)   session <= 1'b0;
      else if (login_ok) session <= 1'b1;
   end

   // R9: any reset event leaves the session closed
   assert_session_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on || reset_cmd) |=> !session);

   // R9: a session only opens after a successful key check
   assert_session_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(session) |-> $past(login_ok));

endmodule

// File: rtl/pa_read_window.sv
module pa_read_window #(
   parameter int ADDR_W    = 8,
   parameter int LAST_ADDR = 33
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*ADDR_W-1:0] loop_field,
   output logic [ADDR_W-1:0]   first_rd,
   output logic [ADDR_W-1:0]   last_rd
);

   localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(LAST_ADDR);

   logic [ADDR_W-1:0] lo, hi;
   logic              pair_ok;

   assign lo      = loop_field[ADDR_W-1:0];
   assign hi      = loop_field[2*ADDR_W-1:ADDR_W];
   assign pair_ok = (lo <= hi) && (hi <= TOP_A);

   assign first_rd = lo;
   assign last_rd  = pair_ok ? hi : lo;

   // R11: the loop end never precedes its start
   assert_loop_ordered_R11: assert property (@(posedge clk) disable iff (!rst_n)
      last_rd >= first_rd);

   // R11: a loop longer than one word never runs past the last word
   assert_loop_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (last_rd != first_rd) |-> (last_rd <= TOP_A));

endmodule

// File: rtl/pa_policy.sv
module pa_policy
   import prot_access_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int LAST_EE     = 31,
   parameter int LAST_ADDR   = 33,
   parameter int KEY_ADDR    = 0,
   parameter int PROT_ADDR   = 1,
   parameter int OPT_ADDR    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  req_kind_e           kind,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [4*ADDR_W-1:0] ranges,
   input  logic                key_check,
   input  logic                rback_en,
   input  logic                session,
   output verdict_t            verdict
);

   localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
   localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(PROT_ADDR);
   localparam logic [ADDR_W-1:0] OPT_A  = ADDR_W'(OPT_ADDR);
   localparam logic [ADDR_W-1:0] EE_A   = ADDR_W'(LAST_EE);
   localparam logic [ADDR_W-1:0] TOP_A  = ADDR_W'(LAST_ADDR);
   localparam int               N_RNG  = 2;

   // range 0: read-protected span, range 1: write-inhibited span
   logic [N_RNG-1:0] hit;

   for (genvar r = 0; r < N_RNG; r++) begin : g_span
      logic [ADDR_W-1:0] lo, hi;
      assign lo     = ranges[(2*r)*ADDR_W +: ADDR_W];
      assign hi     = ranges[(2*r+1)*ADDR_W +: ADDR_W];
      assign hit[r] = (addr >= lo) && (addr <= hi);
   end

   logic in_rp, in_wi, readable;
   assign in_rp    = hit[0];
   assign in_wi    = hit[1];
   assign readable = (addr != KEY_A) && (addr <= TOP_A);

   always_comb begin
      verdict = '{allow: 1'b0, zero: 1'b0};
      unique case (kind)
         KIND_READ: begin
            if (readable) begin
               verdict.allow = 1'b1;
               verdict.zero  = in_rp && !session;
            end else begin
               verdict.zero  = 1'b1;
            end
         end
         KIND_RBACK: begin
            if (readable && rback_en) verdict.allow = 1'b1;
            else                      verdict.zero  = 1'b1;
         end
         KIND_WRITE: begin
            if (addr == KEY_A || addr > EE_A || in_wi)
               verdict.allow = 1'b0;
            else if (addr == PROT_A || addr == OPT_A)
               verdict.allow = session;
            else
               verdict.allow = !key_check || session;
         end
         default: verdict = '{allow: 1'b0, zero: 1'b0};
      endcase
   end

   // R3: the key word is never granted to an ordinary write
   assert_key_unwritable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == KIND_WRITE && addr == KEY_A) |-> !verdict.allow);

   // R6: identity words and anything beyond are read-only
   assert_rom_unwritable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == KIND_WRITE && addr > EE_A) |-> !verdict.allow);

   // R8: a granted read-back is never blanked
   assert_rback_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == KIND_RBACK && verdict.allow) |-> !verdict.zero);

   // R4: configuration words need a session
   assert_cfg_needs_session_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == KIND_WRITE && (addr == PROT_A || addr == OPT_A) && !session)
      |-> !verdict.allow);

endmodule

// File: rtl/prot_access_arbiter.sv
module prot_access_arbiter
   import prot_access_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int LAST_EE   = 31,
   parameter int LAST_ADDR = 33,
   parameter int KEY_ADDR  = 0,
   parameter int PROT_ADDR = 1,
   parameter int OPT_ADDR  = 2,
   parameter int KEYCHK_BIT = 16,
   parameter int RBACK_BIT  = 17,
   parameter bit REG_RSP    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              reset_cmd,
   input  logic              login_ok,
   input  logic [DATA_W-1:0] prot_word,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic              rsp_zero,
   output logic [ADDR_W-1:0] first_rd,
   output logic [ADDR_W-1:0] last_rd
);

   localparam int N_CFG  = 2;
   localparam int IDX_PR = 0;
   localparam int IDX_OP = 1;

   initial begin
      if (4 * ADDR_W > DATA_W)
         $error("protection fields do not fit the data word");
      if (KEYCHK_BIT >= DATA_W || RBACK_BIT >= DATA_W)
         $error("option bit outside the data word");
      if (KEYCHK_BIT < 2 * ADDR_W || RBACK_BIT < 2 * ADDR_W)
         $error("option bit overlaps the loop address fields");
      if (LAST_ADDR >= (1 << ADDR_W) || LAST_EE > LAST_ADDR)
         $error("address limits inconsistent with ADDR_W");
   end

   logic [N_CFG-1:0][DATA_W-1:0] cfg_in, cfg_q;
   logic                         session;
   verdict_t                     verdict;

   assign cfg_in[IDX_PR] = prot_word;
   assign cfg_in[IDX_OP] = ctrl_word;

   pa_cfg_store #(.DATA_W(DATA_W), .N_CFG(N_CFG)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_on    (pwr_on),
      .reset_cmd (reset_cmd),
      .login_ok  (login_ok),
      .cfg_in    (cfg_in),
      .cfg_q     (cfg_q),
      .session   (session)
   );

   pa_read_window #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .loop_field (cfg_q[IDX_OP][2*ADDR_W-1:0]),
      .first_rd   (first_rd),
      .last_rd    (last_rd)
   );

   pa_policy #(
      .ADDR_W    (ADDR_W),
      .LAST_EE   (LAST_EE),
      .LAST_ADDR (LAST_ADDR),
      .KEY_ADDR  (KEY_ADDR),
      .PROT_ADDR (PROT_ADDR),
      .OPT_ADDR  (OPT_ADDR)
   ) u_policy (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .kind      (req_kind_e'(req_kind)),
      .addr      (req_addr),
      .ranges    (cfg_q[IDX_PR][4*ADDR_W-1:0]),
      .key_check (cfg_q[IDX_OP][KEYCHK_BIT]),
      .rback_en  (cfg_q[IDX_OP][RBACK_BIT]),
      .session   (session),
      .verdict   (verdict)
   );

   if (REG_RSP) begin : g_reg_rsp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_zero  <= 1'b0;
         end else begin
            rsp_valid <= req_valid;
            rsp_allow <= req_valid & verdict.allow;
            rsp_zero  <= req_valid & verdict.zero;
         end
      end

      // R2: each request yields a verdict on the following edge
      assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid);

      // R2: no verdict without a request
      assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !rsp_valid && !rsp_allow);
   end else begin : g_comb_rsp
      assign rsp_valid = req_valid;
      assign rsp_allow = req_valid & verdict.allow;
      assign rsp_zero  = req_valid & verdict.zero;
   end

endmodule

// File: tb/prot_access_arbiter_test.sv
`timescale 1ns/1ps
module prot_access_arbiter_test;

   logic        clk = 1'b0;
   logic        rst_n, pwr_on, reset_cmd, login_ok, req_valid;
   logic [31:0] prot_word, ctrl_word;
   logic [1:0]  req_kind;
   logic [7:0]  req_addr;
   logic        rsp_valid, rsp_allow, rsp_zero;
   logic [7:0]  first_rd, last_rd;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   prot_access_arbiter uut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .reset_cmd(reset_cmd),
      .login_ok(login_ok), .prot_word(prot_word), .ctrl_word(ctrl_word),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_zero(rsp_zero),
      .first_rd(first_rd), .last_rd(last_rd)
   );

   localparam logic [1:0] KR = 2'd0, KW = 2'd1, KB = 2'd2, KX = 2'd3;
   // read-protect 5..7, inhibit 10..12
   localparam logic [31:0] P1 = 32'h0C0A_0705;
   // read-protect 0..0, inhibit 1..4 (locks word 1 and 2)
   localparam logic [31:0] P2 = 32'h0401_0000;
   // loop 3..9, key check off, read-back on
   localparam logic [31:0] C1 = 32'h0002_0903;
   // loop 3..9, key check on, read-back off
   localparam logic [31:0] C2 = 32'h0001_0903;

   localparam int VW = 81;
   localparam int NV = 27;
   // {prot, ctrl, session, kind, addr, exp_allow, exp_zero, req}
   localparam logic [VW-1:0] VEC [NV] = '{
      {P1, C1, 1'b0, KW, 8'd0,  1'b0, 1'b0, 4'd3},   // R3
      {P1, C1, 1'b0, KR, 8'd0,  1'b0, 1'b1, 4'd3},   // R3
      {P1, C1, 1'b1, KR, 8'd0,  1'b0, 1'b1, 4'd3},   // R3
      {P1, C1, 1'b0, KW, 8'd1,  1'b0, 1'b0, 4'd4},   // R4
      {P1, C1, 1'b1, KW, 8'd2,  1'b1, 1'b0, 4'd4},   // R4
      {P2, C1, 1'b1, KW, 8'd1,  1'b0, 1'b0, 4'd4},   // R4
      {P2, C1, 1'b1, KW, 8'd2,  1'b0, 1'b0, 4'd4},   // R4
      {P2, C1, 1'b0, KW, 8'd5,  1'b1, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b0, KW, 8'd20, 1'b1, 1'b0, 4'd5},   // R5
      {P1, C2, 1'b0, KW, 8'd20, 1'b0, 1'b0, 4'd5},   // R5
      {P1, C2, 1'b1, KW, 8'd20, 1'b1, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b1, KW, 8'd11, 1'b0, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b1, KW, 8'd12, 1'b0, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b0, KW, 8'd13, 1'b1, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b0, KW, 8'd10, 1'b0, 1'b0, 4'd5},   // R5
      {P1, C1, 1'b1, KW, 8'd32, 1'b0, 1'b0, 4'd6},   // R6
      {P1, C1, 1'b1, KW, 8'd33, 1'b0, 1'b0, 4'd6},   // R6
      {P1, C1, 1'b0, KR, 8'd33, 1'b1, 1'b0, 4'd6},   // R6
      {P1, C1, 1'b0, KR, 8'd34, 1'b0, 1'b1, 4'd6},   // R6
      {P1, C1, 1'b0, KB, 8'd40, 1'b0, 1'b1, 4'd6},   // R6
      {P1, C1, 1'b0, KR, 8'd5,  1'b1, 1'b1, 4'd7},   // R7
      {P1, C1, 1'b0, KR, 8'd7,  1'b1, 1'b1, 4'd7},   // R7
      {P1, C1, 1'b0, KR, 8'd8,  1'b1, 1'b0, 4'd7},   // R7
      {P1, C1, 1'b1, KR, 8'd6,  1'b1, 1'b0, 4'd7},   // R7
      {P1, C1, 1'b0, KB, 8'd6,  1'b1, 1'b0, 4'd8},   // R8
      {P1, C2, 1'b0, KB, 8'd6,  1'b0, 1'b1, 4'd8},   // R8
      {P1, C1, 1'b0, KX, 8'd4,  1'b0, 1'b0, 4'd12}   // R12
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic load_cfg(input logic [31:0] p, input logic [31:0] c);
      @(negedge clk);
      prot_word = p; ctrl_word = c; reset_cmd = 1'b1;
      @(negedge clk);
      reset_cmd = 1'b0;
   endtask

   task automatic pulse_login();
      @(negedge clk) login_ok = 1'b1;
      @(negedge clk) login_ok = 1'b0;
   endtask

   // returns at the falling edge after the verdict was registered
   task automatic do_req(input logic [1:0] k, input logic [7:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; pwr_on = 1'b0; reset_cmd = 1'b0; login_ok = 1'b0;
      prot_word = '0; ctrl_word = '0;
      req_valid = 1'b0; req_kind = '0; req_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
      check("R1 first_rd", {24'd0, first_rd}, 32'd0);
      check("R1 last_rd", {24'd0, last_rd}, 32'd0);
      do_req(KW, 8'd5);
      check("R1 write 5 allowed", {31'd0, rsp_allow}, 32'd1);

      // R2: verdict timing
      check("R2 rsp_valid after request", {31'd0, rsp_valid}, 32'd1);
      @(negedge clk);
      check("R2 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         automatic logic [VW-1:0] v = VEC[i];
         automatic string tag = $sformatf("R%0d vec%0d", v[3:0], i);
         load_cfg(v[80:49], v[48:17]);
         if (v[16]) pulse_login();
         do_req(v[15:14], v[13:6]);
         check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
         check({tag, " allow"}, {31'd0, rsp_allow}, {31'd0, v[5]});
         check({tag, " zero"},  {31'd0, rsp_zero},  {31'd0, v[4]});
      end

      // R9: session lifetime
      load_cfg(P1, C1);
      pulse_login();
      do_req(KR, 8'd6);
      check("R9 session open", {31'd0, rsp_zero}, 32'd0);
      do_req(KR, 8'd6);
      check("R9 session persists", {31'd0, rsp_zero}, 32'd0);
      load_cfg(P1, C1);
      do_req(KR, 8'd6);
      check("R9 closed by reset_cmd", {31'd0, rsp_zero}, 32'd1);
      pulse_login();
      @(negedge clk) pwr_on = 1'b1;
      @(negedge clk) pwr_on = 1'b0;
      do_req(KR, 8'd6);
      check("R9 closed by pwr_on", {31'd0, rsp_zero}, 32'd1);
      @(negedge clk);
      login_ok = 1'b1; reset_cmd = 1'b1;
      @(negedge clk);
      login_ok = 1'b0; reset_cmd = 1'b0;
      do_req(KR, 8'd6);
      check("R9 reset wins over login", {31'd0, rsp_zero}, 32'd1);

      // R10: inputs ignored without a reload
      load_cfg(P1, C1);
      @(negedge clk) ctrl_word = 32'h0001_0507;
      do_req(KW, 8'd20);
      check("R10 key check unchanged", {31'd0, rsp_allow}, 32'd1);
      check("R10 first_rd unchanged", {24'd0, first_rd}, 32'd3);
      load_cfg(P1, 32'h0001_0507);
      do_req(KW, 8'd20);
      check("R10 reload applies key check", {31'd0, rsp_allow}, 32'd0);

      // R11: loop address clamping
      load_cfg(P1, C1);
      check("R11 valid first", {24'd0, first_rd}, 32'd3);
      check("R11 valid last", {24'd0, last_rd}, 32'd9);
      load_cfg(P1, 32'h0000_0309);
      check("R11 reversed first", {24'd0, first_rd}, 32'd9);
      check("R11 reversed last", {24'd0, last_rd}, 32'd9);
      load_cfg(P1, 32'h0000_2805);
      check("R11 beyond top last", {24'd0, last_rd}, 32'd5);
      load_cfg(P1, 32'h0000_2121);
      check("R11 top word first", {24'd0, first_rd}, 32'd33);
      check("R11 top word last", {24'd0, last_rd}, 32'd33);
      load_cfg(P1, 32'h0000_2100);
      check("R11 full span last", {24'd0, last_rd}, 32'd33);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule